// File: doc/BRIEF.md
# Dual-Quantization Correction Code Generator

This block is the digital part of a dual-quantization oversampled DAC. A noise shaper elsewhere produces a three-level coarse code and the error its coarse quantizer made, one sample per oversampled clock. From that error the block builds a second, multibit correction code for a separate 33-level DAC. It negates the error, multiplies it by a programmable fraction below one, rounds the result onto the 33-level grid and takes the first difference of successive levels. The analog side later undoes the fraction and subtracts the correction output from the coarse output.

The coarse code is not changed. It passes through a pure register delay whose length matches the two-clock arithmetic latency of the correction path plus the pipeline latency of the correction DAC. The two codes therefore reach their converters in step. The correction code and its overflow flag share one output valid strobe.

Top module: `dqc_corrgen`

## Requirements
- R1: While `rst_n` is low, and until the first valid sample is processed, `out_valid`, `corr_out`, `corr_ovf` and `coarse_out` are all zero. The stored previous level is zero, so the first correction output after reset equals the first level.
- R2: For a valid sample with error e (signed, `err_in`) and scale K (`scale_k`, unsigned, 16 fractional bits), the scaled value is s = floor((-e*K + 2^15) / 2^16), which rounds to nearest with ties upward.
- R3: The level is L = floor((s + 2^14) / 2^15), clamped to the range -16..+16. Level L stands for the DAC value L*2^15, so full scale is +/-2^19.
- R4: For each valid sample, the correction code is the level minus the level of the previous valid sample. It is signed two's complement on `corr_out`.
- R5: A difference above +16 is output as +16, and a difference below -16 is output as -16. In both cases `corr_ovf` is 1 for that sample and 0 for every sample that is not saturated.
- R6: `out_valid` equals `in_valid` delayed by two clocks. `corr_out` and `corr_ovf` change only when `out_valid` is 1 and hold their values otherwise.
- R7: `coarse_out` equals `coarse_in` delayed by exactly 2+DAC_LAT clocks (DAC_LAT from 0 to 7), bit for bit. The delay advances every clock, whatever `in_valid` is. The code 01 is +1, 00 is 0 and 11 is -1, and any 2-bit pattern passes through unaltered.
- R8: Clocks with `in_valid` low leave the stored previous level untouched. The difference always spans consecutive valid samples, however many idle clocks lie between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampled clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A new error sample is present |
| err_in | input | ERR_W | Coarse quantizer error, signed |
| scale_k | input | SCALE_W | Scale factor, unsigned, SCALE_FRAC fractional bits |
| coarse_in | input | CODE_W | Three-level coarse code |
| out_valid | output | 1 | Correction code valid strobe |
| corr_out | output | OUT_W | Differenced correction level, signed |
| corr_ovf | output | 1 | Difference was saturated |
| coarse_out | output | CODE_W | Delayed coarse code |

## Verification
A sample driven in one clock gives its correction code, overflow flag and valid strobe two clocks later. The coarse code reappears 2+DAC_LAT clocks later. The bench keeps a per-clock history of what it drove and of the model's results. At each falling edge, before it drives new inputs, it compares the outputs with the history entry from two clocks back for the correction path and from 2+DAC_LAT clocks back for the coarse path. It also checks every idle clock, so the hold behaviour is verified at the ports as well.

// File: rtl/dqc_pkg.sv
package dqc_pkg;
   // arithmetic latency of the correction path in clocks
   localparam int CORR_LAT    = 2;
   // largest extra delay for the correction DAC pipeline
   localparam int MAX_DAC_LAT = 7;

   // coarse three-level code values (passed through verbatim)
   typedef enum logic [1:0] {
      CC_ZERO = 2'b00,
      CC_POS  = 2'b01,
      CC_NEG  = 2'b11
   } coarse_code_e;
endpackage

// File: rtl/dqc_scale_quant.sv
module dqc_scale_quant #(
   parameter int ERR_W       = 22,
   parameter int SCALE_W     = 17,
   parameter int SCALE_FRAC  = 16,
   parameter int LVL_SHIFT   = 15,
   parameter int HALF_LEVELS = 16,
   parameter int OUT_W       = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    valid_i,
   input  logic [ERR_W-1:0]        err_i,
   input  logic [SCALE_W-1:0]      scale_i,
   output logic                    valid_o,
   output logic signed [OUT_W-1:0] lvl_o
);
   localparam int PW = ERR_W + SCALE_W + 2;
   localparam logic signed [PW-1:0] RND_A  = PW'(1) << (SCALE_FRAC - 1);
   localparam logic signed [PW-1:0] RND_B  = PW'(1) << (LVL_SHIFT - 1);
   localparam logic signed [PW-1:0] LVL_HI = PW'(HALF_LEVELS);
   localparam logic signed [PW-1:0] LVL_LO = -PW'(HALF_LEVELS);

   generate
      if (SCALE_FRAC < 1 || SCALE_FRAC >= SCALE_W) begin : g_bad_frac
         $error("dqc_scale_quant: SCALE_FRAC out of range");
      end
      if (LVL_SHIFT < 1) begin : g_bad_shift
         $error("dqc_scale_quant: LVL_SHIFT must be positive");
      end
   endgenerate

   logic signed [PW-1:0] neg_err;
   logic signed [PW-1:0] scale_ext;
   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] scaled;
   logic signed [PW-1:0] lvl_wide;
   logic signed [OUT_W-1:0] lvl_clamped;

   assign neg_err   = -{{(PW-ERR_W){err_i[ERR_W-1]}}, err_i};
   assign scale_ext = {{(PW-SCALE_W){1'b0}}, scale_i};
   assign prod      = neg_err * scale_ext;
   assign scaled    = (prod + RND_A) >>> SCALE_FRAC;
   assign lvl_wide  = (scaled + RND_B) >>> LVL_SHIFT;

   always_comb begin
      if (lvl_wide > LVL_HI)
         lvl_clamped = OUT_W'(HALF_LEVELS);
      else if (lvl_wide < LVL_LO)
         lvl_clamped = -OUT_W'(HALF_LEVELS);
      else
         lvl_clamped = lvl_wide[OUT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         lvl_o   <= '0;
      end else begin
         valid_o <= valid_i;
         if (valid_i)
            lvl_o <= lvl_clamped;
      end
   end

   // R3
   lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (lvl_o <= OUT_W'(HALF_LEVELS) && lvl_o >= -OUT_W'(HALF_LEVELS)));
endmodule

// File: rtl/dqc_diff.sv
module dqc_diff #(
   parameter int HALF_LEVELS = 16,
   parameter int OUT_W       = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    valid_i,
   input  logic signed [OUT_W-1:0] lvl_i,
   output logic                    valid_o,
   output logic signed [OUT_W-1:0] diff_o,
   output logic                    ovf_o
);
   localparam int DW = OUT_W + 1;
   localparam logic signed [DW-1:0] D_HI = DW'(HALF_LEVELS);
   localparam logic signed [DW-1:0] D_LO = -DW'(HALF_LEVELS);

   logic signed [OUT_W-1:0] prev_lvl;
   logic signed [DW-1:0]    raw_diff;
   logic signed [OUT_W-1:0] sat_diff;
   logic                    sat_hit;

   assign raw_diff = {lvl_i[OUT_W-1], lvl_i} - {prev_lvl[OUT_W-1], prev_lvl};

   always_comb begin
      sat_hit  = 1'b1;
      sat_diff = OUT_W'(HALF_LEVELS);
      if (raw_diff < D_LO) begin
         sat_diff = -OUT_W'(HALF_LEVELS);
      end else if (raw_diff <= D_HI) begin
         sat_hit  = 1'b0;
         sat_diff = raw_diff[OUT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_lvl <= '0;
         diff_o   <= '0;
         ovf_o    <= 1'b0;
         valid_o  <= 1'b0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) begin
            prev_lvl <= lvl_i;
            diff_o   <= sat_diff;
            ovf_o    <= sat_hit;
         end
      end
   end

   // R5
   diff_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (diff_o <= OUT_W'(HALF_LEVELS) && diff_o >= -OUT_W'(HALF_LEVELS)));
   // R5
   ovf_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> (diff_o == OUT_W'(HALF_LEVELS) || diff_o == -OUT_W'(HALF_LEVELS)));
   // R6
   hold_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> ($stable(diff_o) && $stable(ovf_o)));
   // R8
   hold_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> $stable(prev_lvl));
endmodule

// File: rtl/dqc_delay.sv
module dqc_delay #(
   parameter int W     = 2,
   parameter int DEPTH = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] d_o
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("dqc_delay: DEPTH must be at least 1");
      end
   endgenerate

   logic [W-1:0] stage [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               stage[i] <= '0;
            else if (i == 0)
               stage[i] <= d_i;
            else
               stage[i] <= stage[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign d_o = stage[DEPTH-1];
endmodule

// File: rtl/dqc_corrgen.sv
module dqc_corrgen
   import dqc_pkg::*;
#(
   parameter int ERR_W       = 22,
   parameter int SCALE_W     = 17,
   parameter int SCALE_FRAC  = 16,
   parameter int LVL_SHIFT   = 15,
   parameter int HALF_LEVELS = 16,
   parameter int CODE_W      = 2,
   parameter int DAC_LAT     = 1,
   localparam int OUT_W      = $clog2(HALF_LEVELS) + 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [ERR_W-1:0]        err_in,
   input  logic [SCALE_W-1:0]      scale_k,
   input  logic [CODE_W-1:0]       coarse_in,
   output logic                    out_valid,
   output logic signed [OUT_W-1:0] corr_out,
   output logic                    corr_ovf,
   output logic [CODE_W-1:0]       coarse_out
);
   localparam int CODE_LAT = CORR_LAT + DAC_LAT;
   localparam int CNT_W    = $clog2(CODE_LAT + 2) + 1;

   generate
      if (DAC_LAT < 0 || DAC_LAT > MAX_DAC_LAT) begin : g_bad_lat
         $error("dqc_corrgen: DAC_LAT out of range");
      end
   endgenerate

   logic                    sq_valid;
   logic signed [OUT_W-1:0] sq_lvl;

   dqc_scale_quant #(
      .ERR_W(ERR_W), .SCALE_W(SCALE_W), .SCALE_FRAC(SCALE_FRAC),
      .LVL_SHIFT(LVL_SHIFT), .HALF_LEVELS(HALF_LEVELS), .OUT_W(OUT_W)
   ) u_sq (
      .clk(clk), .rst_n(rst_n), .valid_i(in_valid), .err_i(err_in),
      .scale_i(scale_k), .valid_o(sq_valid), .lvl_o(sq_lvl)
   );

   dqc_diff #(
      .HALF_LEVELS(HALF_LEVELS), .OUT_W(OUT_W)
   ) u_diff (
      .clk(clk), .rst_n(rst_n), .valid_i(sq_valid), .lvl_i(sq_lvl),
      .valid_o(out_valid), .diff_o(corr_out), .ovf_o(corr_ovf)
   );

   dqc_delay #(
      .W(CODE_W), .DEPTH(CODE_LAT)
   ) u_align (
      .clk(clk), .rst_n(rst_n), .d_i(coarse_in), .d_o(coarse_out)
   );

   // cycles since reset release, used to keep history checks in range
   logic [CNT_W-1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since_rst <= '0;
      else if (since_rst <= CNT_W'(CODE_LAT + 1))
         since_rst <= since_rst + 1'b1;
   end

   // R6
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst > CNT_W'(CORR_LAT)) |-> (out_valid == $past(in_valid, CORR_LAT)));
   // R7
   code_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst > CNT_W'(CODE_LAT)) |-> (coarse_out == $past(coarse_in, CODE_LAT)));
endmodule

// File: tb/dqc_corrgen_test.sv
module dqc_corrgen_test;
   localparam int DAC_LAT  = 1;
   localparam int CODE_LAT = 2 + DAC_LAT;
   localparam int HL       = 4096;
   localparam int NV       = 14;

   // error, scale, valid, coarse code
   localparam int VE [NV] = '{0, -262144, 0, 262144, -2097152, 2097151, -16384,
                              16384, -100000, -12345, 99999, 500000, -500000, 32767};
   localparam int VK [NV] = '{49152, 49152, 49152, 49152, 65536, 65536, 65536,
                              65536, 0, 40000, 58000, 30000, 30000, 65535};
   localparam int VV [NV] = '{1, 1, 0, 1, 1, 1, 1, 1, 1, 1, 0, 1, 1, 1};
   localparam int VC [NV] = '{1, 3, 0, 1, 2, 3, 1, 0, 3, 1, 0, 3, 1, 2};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [21:0]       err_in = '0;
   logic [16:0]       scale_k = '0;
   logic [1:0]        coarse_in = '0;
   logic              out_valid;
   logic signed [5:0] corr_out;
   logic              corr_ovf;
   logic [1:0]        coarse_out;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int model_prev = 0;
   int held_w = 0;
   int held_o = 0;
   int h_code [HL];
   int h_val  [HL];
   int h_w    [HL];
   int h_ovf  [HL];

   always #10 clk = ~clk;

   dqc_corrgen #(.DAC_LAT(DAC_LAT)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .err_in(err_in),
      .scale_k(scale_k), .coarse_in(coarse_in), .out_valid(out_valid),
      .corr_out(corr_out), .corr_ovf(corr_ovf), .coarse_out(coarse_out)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // R2 R3: level from error and scale
   function automatic int level_of(input int e, input int k);
      longint p, s, l;
      p = -longint'(e) * longint'(k);
      s = (p + 64'sd32768) >>> 16;
      l = (s + 64'sd16384) >>> 15;
      if (l > 16) l = 16;
      if (l < -16) l = -16;
      return int'(l);
   endfunction

   task automatic clear_model();
      for (int i = 0; i < HL; i++) begin
         h_code[i] = 0; h_val[i] = 0; h_w[i] = 0; h_ovf[i] = 0;
      end
      cyc = 0; model_prev = 0; held_w = 0; held_o = 0;
   endtask

   task automatic step(input int v, input int e, input int k, input int c);
      int d;
      int lv;
      @(negedge clk);
      if (cyc >= 2 && h_val[cyc-2] != 0) begin
         held_w = h_w[cyc-2];
         held_o = h_ovf[cyc-2];
      end
      check("R6 out_valid", int'(out_valid), (cyc >= 2) ? h_val[cyc-2] : 0);
      check("R4 corr_out", int'(corr_out), held_w);
      check("R5 corr_ovf", int'(corr_ovf), held_o);
      check("R7 coarse_out", int'(coarse_out), (cyc >= CODE_LAT) ? h_code[cyc-CODE_LAT] : 0);
      in_valid  = v[0];
      err_in    = e[21:0];
      scale_k   = k[16:0];
      coarse_in = c[1:0];
      h_code[cyc] = c & 3;
      h_val[cyc]  = v;
      if (v != 0) begin
         lv = level_of(e, k);
         d  = lv - model_prev;   // R8: only valid samples advance
         model_prev = lv;
         h_ovf[cyc] = (d > 16 || d < -16) ? 1 : 0;
         h_w[cyc]   = (d > 16) ? 16 : (d < -16) ? -16 : d;
      end
      cyc++;
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      clear_model();
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 out_valid", int'(out_valid), 0);
      check("R1 corr_out", int'(corr_out), 0);
      check("R1 corr_ovf", int'(corr_ovf), 0);
      check("R1 coarse_out", int'(coarse_out), 0);
      rst_n = 1'b1;

      // table walk (R2 R3 R4 R5 R6 R7 R8)
      for (int i = 0; i < NV; i++) step(VV[i], VE[i], VK[i], VC[i]);
      // R8: long idle gap then one sample, difference spans the gap
      for (int i = 0; i < 5; i++) step(0, 777777, 65535, i & 3);
      step(1, -131072, 65535, 1);
      // R5: back-to-back full swings
      for (int i = 0; i < 6; i++) step(1, (i % 2 == 0) ? -2000000 : 2000000, 65536, 3);
      // drain
      for (int i = 0; i < CODE_LAT + 2; i++) step(0, 0, 0, 0);

      // R1: mid-run reset clears delay line and previous level
      step(1, -1000000, 65536, 2);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 out_valid after reset", int'(out_valid), 0);
      check("R1 corr_out after reset", int'(corr_out), 0);
      check("R1 coarse_out after reset", int'(coarse_out), 0);
      rst_n = 1'b1;
      in_valid = 1'b0;
      coarse_in = '0;
      clear_model();
      // first sample after reset: difference equals the level (R1)
      step(1, -98304, 65536, 1);
      for (int i = 0; i < CODE_LAT + 2; i++) step(0, 0, 0, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule